// File: doc/BRIEF.md
# Iterative Integer Divider with Running Overflow Detection

This block is the divide unit of a CPU execute stage. A one-cycle start pulse hands it a 64-bit dividend, a 64-bit divisor and three mode bits: signed or unsigned, full-width or word, and whether the condition field should be updated. It works out the quotient with a restoring shift-subtract loop that produces one quotient bit per clock. After a fixed number of cycles it presents the quotient, an overflow flag and the two write enables together for a single cycle.

In signed mode the unit first replaces both operands by their magnitudes. It negates the quotient at the end when exactly one operand was negative. In word mode the full 64-bit dividend is divided by a 32-bit divisor, and the quotient must fit in 32 bits. The unit watches the quotient register while the loop runs and records any 1 that moves past bit 31, so no wide comparison is needed at the end. The negation and range checks feed a register stage, and every result signal comes out of that register.

Top module: `iter_divider`

## Requirements
- R1: While reset is held and after it is released, valid_o, wr_reg_o and wr_cr_o are low, and quot_o and ovf_o are zero, until the first result is produced.
- R2: A start_i sampled high at a rising edge while the unit is idle produces valid_o high after the 66th rising edge that follows. valid_o is high for exactly one cycle. A start_i held during the cycle in which valid_o is high is accepted.
- R3: A start_i sampled while a division is in progress is ignored. The result that comes out is the one for the operands accepted earlier.
- R4: In unsigned full-width mode (signed_i=0, word_i=0) with a nonzero divisor, quot_o is floor(dividend/divisor) and ovf_o is 0.
- R5: In signed full-width mode the quotient is truncated toward zero and is negative exactly when the operand signs differ. -2^63 divided by -1 sets ovf_o.
- R6: A divisor of zero sets ovf_o and gives quot_o = 0 in every mode. In word mode only divisor bits 31:0 are tested.
- R7: In unsigned word mode the divisor is divisor_i[31:0] zero-extended and the dividend is the full 64-bit value. A quotient of 2^32 or more sets ovf_o. Otherwise quot_o is the quotient, zero-extended.
- R8: In signed word mode the divisor is divisor_i[31:0] sign-extended and the dividend is the full signed 64-bit value. A quotient outside [-2^31, 2^31-1] sets ovf_o. Otherwise quot_o is the 32-bit quotient sign-extended to 64 bits.
- R9: wr_reg_o is high exactly when valid_o is high. wr_cr_o is high exactly when valid_o is high and rc_i was 1 with the accepted start.
- R10: Whenever ovf_o is set with a result, quot_o is zero. quot_o and ovf_o hold their values from the last result until the next result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start request, sampled only while idle |
| dividend_i | input | 64 | Dividend |
| divisor_i | input | 64 | Divisor (word mode uses bits 31:0) |
| signed_i | input | 1 | 1 = two's-complement operands |
| word_i | input | 1 | 1 = 32-bit quotient mode |
| rc_i | input | 1 | Request a condition-field update with the result |
| valid_o | output | 1 | One-cycle result strobe |
| quot_o | output | 64 | Quotient |
| ovf_o | output | 1 | Overflow or divide by zero |
| wr_reg_o | output | 1 | Register write enable |
| wr_cr_o | output | 1 | Condition-field write enable |

## Verification
Every result of this unit is due exactly 66 rising edges after the edge that accepted its start. The bench model records that due edge in a queue when it sees an accepted start, and it treats starts that arrive before the unit is free again as ignored. On every falling edge the bench compares all outputs with the model: valid and the write enables must be high only at the queued due edge, and quotient and overflow must hold their last values between results. Because the comparison runs on every cycle, a result one cycle early or late, or a strobe that lasts two cycles, is reported as a miscompare.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_FIN  = 2'd3
  } div_state_e;
endpackage

// File: rtl/div_prep.sv
// Operand conditioning: word-mode divisor extension, magnitudes, result sign.
module div_prep #(
  parameter int DW = 64,
  parameter int HW = 32
) (
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic          sgn_i,
  input  logic          word_i,
  output logic [DW-1:0] mag_a_o,
  output logic [DW-1:0] mag_b_o,
  output logic          neg_res_o,
  output logic          div_zero_o
);
  localparam int EXT = DW - HW;

  logic [DW-1:0] divisor_ext;
  logic          neg_a;
  logic          neg_b;

  always_comb begin
    if (word_i) begin
      if (sgn_i) divisor_ext = {{EXT{opb_i[HW-1]}}, opb_i[HW-1:0]};
      else       divisor_ext = {{EXT{1'b0}}, opb_i[HW-1:0]};
    end else begin
      divisor_ext = opb_i;
    end
    neg_a      = sgn_i & opa_i[DW-1];
    neg_b      = sgn_i & divisor_ext[DW-1];
    mag_a_o    = neg_a ? (~opa_i + 1'b1) : opa_i;
    mag_b_o    = neg_b ? (~divisor_ext + 1'b1) : divisor_ext;
    neg_res_o  = neg_a ^ neg_b;
    div_zero_o = (divisor_ext == '0);
  end
endmodule

// File: rtl/div_core.sv
// Restoring shift-subtract loop, one quotient bit per enabled cycle,
// with a sticky flag for word-mode bits leaving the low half.
module div_core #(
  parameter int DW = 64,
  parameter int HW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          word_i,
  input  logic [DW-1:0] mag_a_i,
  input  logic [DW-1:0] mag_b_i,
  output logic [DW-1:0] quo_o,
  output logic          hi_ovf_o
);
  logic [DW-1:0] rem_q, rem_d;
  logic [DW-1:0] dvd_q, dvd_d;
  logic [DW-1:0] dvs_q, dvs_d;
  logic [DW-1:0] quo_q, quo_d;
  logic          sticky_q, sticky_d;
  logic          en;
  logic [DW:0]   trial;
  logic [DW:0]   diff;
  logic          take;

  assign en = load_i | step_i;

  always_comb begin
    trial    = {rem_q, dvd_q[DW-1]};
    diff     = trial - {1'b0, dvs_q};
    take     = ~diff[DW];
    rem_d    = rem_q;
    dvd_d    = dvd_q;
    dvs_d    = dvs_q;
    quo_d    = quo_q;
    sticky_d = sticky_q;
    if (load_i) begin
      rem_d    = '0;
      dvd_d    = mag_a_i;
      dvs_d    = mag_b_i;
      quo_d    = '0;
      sticky_d = 1'b0;
    end else if (step_i) begin
      rem_d    = take ? diff[DW-1:0] : trial[DW-1:0];
      dvd_d    = {dvd_q[DW-2:0], 1'b0};
      quo_d    = {quo_q[DW-2:0], take};
      sticky_d = sticky_q | (word_i & quo_q[HW-1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q    <= '0;
      dvd_q    <= '0;
      dvs_q    <= '0;
      quo_q    <= '0;
      sticky_q <= 1'b0;
    end else if (en) begin
      rem_q    <= rem_d;
      dvd_q    <= dvd_d;
      dvs_q    <= dvs_d;
      quo_q    <= quo_d;
      sticky_q <= sticky_d;
    end
  end

  assign quo_o    = quo_q;
  assign hi_ovf_o = sticky_q;

  // R7/R8: once a bit has left the low half, the flag stays set for the rest of the loop
  a_r7_sticky_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && sticky_q) |=> sticky_q);
  // load and step never coincide
  a_r2_load_step_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i && step_i));
endmodule

// File: rtl/div_fixup.sv
// Sign restore, range checks and result masking.
module div_fixup #(
  parameter int DW = 64,
  parameter int HW = 32
) (
  input  logic [DW-1:0] quo_i,
  input  logic          hi_ovf_i,
  input  logic          neg_res_i,
  input  logic          sgn_i,
  input  logic          word_i,
  input  logic          div_zero_i,
  output logic [DW-1:0] quot_o,
  output logic          ovf_o
);
  localparam int EXT = DW - HW;

  logic [DW-1:0] signed_q;
  logic [DW-1:0] shaped;
  logic          ovf_full;
  logic          ovf_word;
  logic          low_is_min;

  always_comb begin
    signed_q   = neg_res_i ? (~quo_i + 1'b1) : quo_i;
    low_is_min = neg_res_i & (quo_i[HW-2:0] == '0);
    ovf_full   = sgn_i & ~neg_res_i & quo_i[DW-1];
    ovf_word   = hi_ovf_i | (sgn_i & quo_i[HW-1] & ~low_is_min);
    ovf_o      = div_zero_i | (word_i ? ovf_word : ovf_full);
    if (word_i) begin
      if (sgn_i) shaped = {{EXT{signed_q[HW-1]}}, signed_q[HW-1:0]};
      else       shaped = {{EXT{1'b0}}, quo_i[HW-1:0]};
    end else begin
      shaped = signed_q;
    end
    quot_o = ovf_o ? '0 : shaped;
  end
endmodule

// File: rtl/iter_divider.sv
module iter_divider #(
  parameter int DW = 64,
  parameter int HW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [DW-1:0] divisor_i,
  input  logic          signed_i,
  input  logic          word_i,
  input  logic          rc_i,
  output logic          valid_o,
  output logic [DW-1:0] quot_o,
  output logic          ovf_o,
  output logic          wr_reg_o,
  output logic          wr_cr_o
);
  import div_pkg::*;

  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  div_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] opa_q, opb_q;
  logic          sgn_q, word_q, rc_q;
  logic          accept;
  logic          load, step, cnt_en;

  logic [DW-1:0] mag_a, mag_b, quo, fix_quot;
  logic          neg_res, div_zero, hi_ovf, fix_ovf;

  assign accept = (state_q == ST_IDLE) & start_i;
  assign load   = (state_q == ST_LOAD);
  assign step   = (state_q == ST_RUN);
  assign cnt_en = load | step;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_LOAD;
      ST_LOAD: begin
        state_d = ST_RUN;
        cnt_d   = '0;
      end
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // operand capture, enabled only on an accepted start
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      opa_q  <= '0;
      opb_q  <= '0;
      sgn_q  <= 1'b0;
      word_q <= 1'b0;
      rc_q   <= 1'b0;
    end else if (accept) begin
      opa_q  <= dividend_i;
      opb_q  <= divisor_i;
      sgn_q  <= signed_i;
      word_q <= word_i;
      rc_q   <= rc_i;
    end
  end

  div_prep #(.DW(DW), .HW(HW)) u_prep (
    .opa_i      (opa_q),
    .opb_i      (opb_q),
    .sgn_i      (sgn_q),
    .word_i     (word_q),
    .mag_a_o    (mag_a),
    .mag_b_o    (mag_b),
    .neg_res_o  (neg_res),
    .div_zero_o (div_zero)
  );

  div_core #(.DW(DW), .HW(HW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load_i   (load),
    .step_i   (step),
    .word_i   (word_q),
    .mag_a_i  (mag_a),
    .mag_b_i  (mag_b),
    .quo_o    (quo),
    .hi_ovf_o (hi_ovf)
  );

  div_fixup #(.DW(DW), .HW(HW)) u_fix (
    .quo_i      (quo),
    .hi_ovf_i   (hi_ovf),
    .neg_res_i  (neg_res),
    .sgn_i      (sgn_q),
    .word_i     (word_q),
    .div_zero_i (div_zero),
    .quot_o     (fix_quot),
    .ovf_o      (fix_ovf)
  );

  // output register stage
  logic fin;
  assign fin = (state_q == ST_FIN);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      valid_o  <= 1'b0;
      wr_reg_o <= 1'b0;
      wr_cr_o  <= 1'b0;
      quot_o   <= '0;
      ovf_o    <= 1'b0;
    end else begin
      valid_o  <= fin;
      wr_reg_o <= fin;
      wr_cr_o  <= fin & rc_q;
      if (fin) begin
        quot_o <= fix_quot;
        ovf_o  <= fix_ovf;
      end
    end
  end

  // R2: the finish state is followed by the strobe
  a_r2_fin_to_valid: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_FIN) |=> valid_o);
  // R2: strobe lasts one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n_s)
    valid_o |=> !valid_o);
  // R3: captured operands do not move while busy
  a_r3_busy_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q != ST_IDLE) |=> ($stable(opa_q) && $stable(opb_q) && $stable(word_q)));
  // R10: overflowed results carry a zero quotient
  a_r10_ovf_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    (valid_o && ovf_o) |-> (quot_o == '0));
  // R9: condition write only alongside register write
  a_r9_cr_gate: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_cr_o |-> (wr_reg_o && valid_o));
  // R7: unsigned word results fit the low half
  a_r7_word_range: assert property (@(posedge clk) disable iff (!rst_n_s)
    (valid_o && word_q && !sgn_q) |-> (quot_o[DW-1:HW] == '0));
endmodule

// File: tb/iter_divider_test.sv
module iter_divider_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 66;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [63:0] dividend_i, divisor_i;
  logic        signed_i, word_i, rc_i;
  logic        valid_o, ovf_o, wr_reg_o, wr_cr_o;
  logic [63:0] quot_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  iter_divider uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .signed_i(signed_i), .word_i(word_i), .rc_i(rc_i),
    .valid_o(valid_o), .quot_o(quot_o), .ovf_o(ovf_o),
    .wr_reg_o(wr_reg_o), .wr_cr_o(wr_cr_o)
  );

  int vectors = 0;
  int miscompares = 0;
  int edge_cnt = 0;
  int free_at = 0;
  string cur_tag = "R4";

  int          due_q[$];
  logic [63:0] expq_q[$];
  logic        expo_q[$];
  logic        exprc_q[$];
  string       tag_q[$];

  logic [63:0] hold_q = '0;
  logic        hold_o = 1'b0;

  function automatic void ref_div(input logic [63:0] a, input logic [63:0] b,
                                  input logic sg, input logic wd,
                                  output logic [63:0] q, output logic ov);
    logic [63:0] bb, ma, mb, mq;
    logic na, nb, ng;
    bb = wd ? (sg ? {{32{b[31]}}, b[31:0]} : {32'h0, b[31:0]}) : b;
    ov = 1'b0;
    q  = '0;
    if (bb == 0) begin
      ov = 1'b1;
    end else if (!sg) begin
      mq = a / bb;
      if (wd && mq[63:32] != 0) ov = 1'b1;
      else q = mq;
    end else begin
      na = a[63]; nb = bb[63]; ng = na ^ nb;
      ma = na ? -a : a;
      mb = nb ? -bb : bb;
      mq = ma / mb;
      if (wd) ov = ng ? (mq > 64'h8000_0000) : (mq > 64'h7FFF_FFFF);
      else    ov = !ng && mq[63];
      if (!ov) q = ng ? -mq : mq;
    end
  endfunction

  // model: accepts starts, schedules results
  always @(posedge clk) begin
    edge_cnt = edge_cnt + 1;
    if (rst_n && start_i && edge_cnt >= free_at) begin
      logic [63:0] q; logic ov;
      ref_div(dividend_i, divisor_i, signed_i, word_i, q, ov);
      due_q.push_back(edge_cnt + LAT);
      expq_q.push_back(q);
      expo_q.push_back(ov);
      exprc_q.push_back(rc_i);
      tag_q.push_back(cur_tag);
      free_at = edge_cnt + LAT + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at edge %0d", tag, act, exp, edge_cnt);
    end
  endtask

  // compare every cycle
  always @(negedge clk) begin
    logic ev; logic erc; string t;
    vectors++;
    if (!rst_n) begin
      chk("R1 valid", {63'b0, valid_o}, 64'd0);
      chk("R1 quot", quot_o, 64'd0);
      chk("R1 ovf", {63'b0, ovf_o}, 64'd0);
    end else begin
      ev = (due_q.size() > 0) && (due_q[0] == edge_cnt);
      erc = 1'b0;
      t = "R10 hold";
      if (ev) begin
        void'(due_q.pop_front());
        hold_q = expq_q.pop_front();
        hold_o = expo_q.pop_front();
        erc = exprc_q.pop_front();
        t = tag_q.pop_front();
      end
      chk("R2 valid timing", {63'b0, valid_o}, {63'b0, ev});
      chk("R9 wr_reg", {63'b0, wr_reg_o}, {63'b0, ev});
      chk("R9 wr_cr", {63'b0, wr_cr_o}, {63'b0, erc});
      chk({t, " quot"}, quot_o, hold_q);
      chk({t, " ovf"}, {63'b0, ovf_o}, {63'b0, hold_o});
    end
  end

  task automatic launch(input logic [63:0] a, input logic [63:0] b,
                        input logic sg, input logic wd, input logic rc, input string tag);
    cur_tag = tag;
    dividend_i = a; divisor_i = b; signed_i = sg; word_i = wd; rc_i = rc;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run(input logic [63:0] a, input logic [63:0] b,
                     input logic sg, input logic wd, input logic rc, input string tag);
    launch(a, b, sg, wd, rc, tag);
    repeat (LAT + 3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0;
    dividend_i = '0; divisor_i = '0; signed_i = 0; word_i = 0; rc_i = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R4 unsigned full width
    run(64'd100, 64'd7, 0, 0, 1, "R4");
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 0, 0, 0, "R4");
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0, "R4");
    run(64'd5, 64'd9, 0, 0, 1, "R4");
    // R6 divide by zero
    run(64'd1234, 64'd0, 0, 0, 0, "R6");
    run(64'd1234, 64'hFFFF_FFFF_0000_0000, 1, 1, 0, "R6");
    // R5 signed full width
    run(-64'sd100, 64'd7, 1, 0, 1, "R5");
    run(64'd100, -64'sd7, 1, 0, 0, "R5");
    run(-64'sd100, -64'sd7, 1, 0, 0, "R5");
    run(64'h8000_0000_0000_0000, -64'sd1, 1, 0, 0, "R5");
    run(64'h8000_0000_0000_0000, 64'd1, 1, 0, 0, "R5");
    // R7 unsigned word
    run(64'h0000_0100_0000_0000, 64'd3, 0, 1, 0, "R7");
    run(64'd1000, 64'hFFFF_FFFF_0000_0021, 0, 1, 1, "R7");
    run(64'h0000_0000_FFFF_FFFF, 64'd1, 0, 1, 0, "R7");
    run(64'h0000_0001_0000_0000, 64'd1, 0, 1, 0, "R7");
    // R8 signed word
    run(-64'sd2147483648, 64'd1, 1, 1, 0, "R8");
    run(64'd2147483648, 64'd1, 1, 1, 0, "R8");
    run(-64'sd2147483648, 64'hFFFF_FFFF, 1, 1, 0, "R8");
    run(64'd2147483647, 64'd1, 1, 1, 0, "R8");
    run(-64'sd700, 64'h0000_0000_FFFF_FFF9, 1, 1, 1, "R8");
    // R3 start while busy is ignored
    launch(64'd90, 64'd9, 0, 0, 0, "R3");
    repeat (10) @(negedge clk);
    launch(64'd77, 64'd1, 0, 0, 1, "R3 ignored");
    repeat (LAT) @(negedge clk);
    // R2 back-to-back: start during the valid cycle
    launch(64'd50, 64'd5, 0, 0, 1, "R2");
    repeat (LAT) @(negedge clk);
    launch(64'd81, 64'd3, 0, 0, 0, "R2");
    repeat (LAT + 3) @(negedge clk);
    // R10 hold after a long idle stretch
    repeat (20) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule